// File: doc/BRIEF.md
# Prefix-Instruction Fusion Stage

This stage sits after the instruction buffer and before the main decoder. It watches the incoming instruction records for a register-copy prefix (`Zd <= Za`) that is directly followed by a destructive multiply-add (`Zd <= Zd + Zn*Zm`) writing the same register. When it finds such a pair, it emits a single four-operand micro-op, `Zd <= Za + Zn*Zm`. That micro-op then takes one decode, dispatch and commit slot instead of two. Every other record passes through unchanged and in order.

A prefix has to wait to learn whether a matching multiply-add follows, so the stage parks it in a one-entry hold slot. If no input arrives, the prefix waits for up to `HOLD_CYCLES` idle input cycles and is then sent on alone. A fused micro-op carries two program counters: the prefix's and the multiply-add's. A later stage can therefore blame a fault on the right instruction.

Both streams use valid/ready handshakes, and a transfer happens on a rising clock edge where both are high. `out_valid` and every output field stay stable while `out_ready` is low. `in_ready` may depend on `in_valid` and `in_cls` in the same cycle, but `in_valid` must not depend on `in_ready`. When the output is stalled, the stage accepts nothing.

Top module: `pfx_fuse_stage`

## Requirements
- R1: After reset, `out_valid` is 0, and it stays 0 until a record has been accepted.
- R2: A prefix (class 1) followed by a multiply-add (class 2) with an equal `in_dst` gives exactly one output. That output has kind 3, the multiply-add's `dst`, `sa` = the prefix's `in_sa`, `sn` = the multiply-add's `in_sa`, and `sm` = the multiply-add's `in_sb`.
- R3: In a fused output, `out_pc` is the prefix's `in_pc` and `out_pc2` is the multiply-add's `in_pc`.
- R4: When the multiply-add's `in_dst` differs from the held prefix's, the prefix is emitted alone, followed by the multiply-add alone.
- R5: A prefix followed by a class-0 record is emitted alone, followed by that record.
- R6: A held prefix with no valid input is emitted alone after `HOLD_CYCLES` idle input cycles. A multiply-add arriving after at most `HOLD_CYCLES` idle cycles still fuses.
- R7: The outputs follow input order. Each input appears in exactly one output.
- R8: While `out_valid` is high and `out_ready` is low, the output fields are stable and `in_ready` is low.
- R9: A prefix followed by another prefix causes the first to be emitted alone, while the second is held.
- R10: A record that is not fused leaves with its kind equal to its `in_cls`. Its `out_dst`, `out_sa` and `out_sn` are copied from `in_dst`, `in_sa` and `in_sb`, `out_sm` is 0, and `out_pc2` equals `out_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Stage accepts the input record this cycle |
| in_cls | input | 2 | Record class: 0 other, 1 copy prefix, 2 destructive multiply-add |
| in_dst | input | REG_W | Destination register |
| in_sa | input | REG_W | First source (copy source, or first multiplicand) |
| in_sb | input | REG_W | Second source (second multiplicand) |
| in_pc | input | PC_W | Program counter of the record |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Downstream accepts the micro-op |
| out_kind | output | 2 | 0 other, 1 prefix alone, 2 multiply-add alone, 3 fused four-operand |
| out_dst | output | REG_W | Destination register |
| out_sa | output | REG_W | Addend source (fused) or copied `in_sa` |
| out_sn | output | REG_W | First multiplicand (fused) or copied `in_sb` |
| out_sm | output | REG_W | Second multiplicand (fused), otherwise 0 |
| out_pc | output | PC_W | Program counter of the first instruction |
| out_pc2 | output | PC_W | Program counter of the second instruction, or `out_pc` |

## Verification
The hold slot is the risky state. If it kept a stale valid bit, a prefix would be emitted twice or not at all, and the very next output would show a duplicate or the wrong order. A miscounted idle timer shows up one or two cycles later: a multiply-add that should fuse leaves separately, or a tail prefix never leaves. A wrong match on the destination shows at once as a kind-3 output with the wrong `dst` or `pc2`. Each of these is caught by comparing the output stream, entry by entry, against a queue computed from the input order, the destinations and the idle gaps.

// File: rtl/pfx_fuse_pkg.sv
package pfx_fuse_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_PFX   = 2'd1,
    CLS_FMA3  = 2'd2,
    CLS_FMA4  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    SEL_IN   = 2'd0,
    SEL_HOLD = 2'd1,
    SEL_FUSE = 2'd2
  } sel_e;
endpackage

// File: rtl/pfx_fuse_hold.sv
module pfx_fuse_hold #(
  parameter int REG_W       = 5,
  parameter int PC_W        = 32,
  parameter int HOLD_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic             in_idle,
  input  logic [REG_W-1:0] d_dst,
  input  logic [REG_W-1:0] d_sa,
  input  logic [REG_W-1:0] d_sb,
  input  logic [PC_W-1:0]  d_pc,
  output logic             hold_v,
  output logic [REG_W-1:0] h_dst,
  output logic [REG_W-1:0] h_sa,
  output logic [REG_W-1:0] h_sb,
  output logic [PC_W-1:0]  h_pc,
  output logic             expired
);
  localparam int AGE_W = $clog2(HOLD_CYCLES + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(HOLD_CYCLES);

  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      age    <= '0;
      h_dst  <= '0;
      h_sa   <= '0;
      h_sb   <= '0;
      h_pc   <= '0;
    end else if (load) begin
      hold_v <= 1'b1;
      age    <= '0;
      h_dst  <= d_dst;
      h_sa   <= d_sa;
      h_sb   <= d_sb;
      h_pc   <= d_pc;
    end else if (clear) begin
      hold_v <= 1'b0;
      age    <= '0;
    end else if (hold_v && in_idle && (age < AGE_MAX)) begin
      age <= age + 1'b1;
    end
  end

  assign expired = hold_v && (age == AGE_MAX);

  AST_AGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    age <= AGE_MAX); // R6
  AST_IDLE_ONLY_AGES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !in_idle && !load && !clear) |=> $stable(age)); // R6
endmodule

// File: rtl/pfx_fuse_merge.sv
module pfx_fuse_merge
  import pfx_fuse_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int PC_W  = 32
) (
  input  logic             hold_v,
  input  logic [REG_W-1:0] h_dst,
  input  logic [REG_W-1:0] h_sa,
  input  logic [REG_W-1:0] h_sb,
  input  logic [PC_W-1:0]  h_pc,
  input  logic             in_valid,
  input  logic [1:0]       in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_sa,
  input  logic [REG_W-1:0] in_sb,
  input  logic [PC_W-1:0]  in_pc,
  input  sel_e             sel,
  output logic             hit,
  output logic [1:0]       u_kind,
  output logic [REG_W-1:0] u_dst,
  output logic [REG_W-1:0] u_sa,
  output logic [REG_W-1:0] u_sn,
  output logic [REG_W-1:0] u_sm,
  output logic [PC_W-1:0]  u_pc,
  output logic [PC_W-1:0]  u_pc2
);
  assign hit = hold_v && in_valid && (cls_e'(in_cls) == CLS_FMA3) && (in_dst == h_dst);

  always_comb begin
    u_kind = in_cls;
    u_dst  = in_dst;
    u_sa   = in_sa;
    u_sn   = in_sb;
    u_sm   = '0;
    u_pc   = in_pc;
    u_pc2  = in_pc;
    unique case (sel)
      SEL_HOLD: begin
        u_kind = CLS_PFX;
        u_dst  = h_dst;
        u_sa   = h_sa;
        u_sn   = h_sb;
        u_pc   = h_pc;
        u_pc2  = h_pc;
      end
      SEL_FUSE: begin
        u_kind = CLS_FMA4;
        u_dst  = in_dst;
        u_sa   = h_sa;
        u_sn   = in_sa;
        u_sm   = in_sb;
        u_pc   = h_pc;
        u_pc2  = in_pc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pfx_fuse_outreg.sv
module pfx_fuse_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emit,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] dout,
  output logic         can_load
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (can_load) begin
      out_valid <= emit;
      if (emit) dout <= din;
    end
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout))); // R8
endmodule

// File: rtl/pfx_fuse_stage.sv
module pfx_fuse_stage
  import pfx_fuse_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter int PC_W        = 32,
  parameter int HOLD_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_sa,
  input  logic [REG_W-1:0] in_sb,
  input  logic [PC_W-1:0]  in_pc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [REG_W-1:0] out_dst,
  output logic [REG_W-1:0] out_sa,
  output logic [REG_W-1:0] out_sn,
  output logic [REG_W-1:0] out_sm,
  output logic [PC_W-1:0]  out_pc,
  output logic [PC_W-1:0]  out_pc2
);
  localparam int UOP_W = 2 + 4 * REG_W + 2 * PC_W;

  logic             hold_v, expired, hit, adv;
  logic [REG_W-1:0] h_dst, h_sa, h_sb;
  logic [PC_W-1:0]  h_pc;
  logic             emit, consume, load_h, clr_h;
  sel_e             sel;
  logic [1:0]       u_kind;
  logic [REG_W-1:0] u_dst, u_sa, u_sn, u_sm;
  logic [PC_W-1:0]  u_pc, u_pc2;
  logic [UOP_W-1:0] uop_d, uop_q;
  logic             in_is_pfx;

  assign in_is_pfx = cls_e'(in_cls) == CLS_PFX;

  always_comb begin
    emit    = 1'b0;
    consume = 1'b0;
    load_h  = 1'b0;
    clr_h   = 1'b0;
    sel     = SEL_IN;
    if (adv) begin
      if (hold_v) begin
        if (hit) begin
          emit = 1'b1; consume = 1'b1; clr_h = 1'b1; sel = SEL_FUSE;
        end else if (in_valid) begin
          emit = 1'b1; clr_h = 1'b1; sel = SEL_HOLD;
          if (in_is_pfx) begin
            consume = 1'b1; load_h = 1'b1;
          end
        end else if (expired) begin
          emit = 1'b1; clr_h = 1'b1; sel = SEL_HOLD;
        end
      end else if (in_valid) begin
        consume = 1'b1;
        if (in_is_pfx) load_h = 1'b1;
        else           emit   = 1'b1;
      end
    end
  end

  assign in_ready = consume;

  pfx_fuse_hold #(.REG_W(REG_W), .PC_W(PC_W), .HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load_h), .clear(clr_h), .in_idle(!in_valid),
    .d_dst(in_dst), .d_sa(in_sa), .d_sb(in_sb), .d_pc(in_pc),
    .hold_v(hold_v), .h_dst(h_dst), .h_sa(h_sa), .h_sb(h_sb), .h_pc(h_pc),
    .expired(expired)
  );

  pfx_fuse_merge #(.REG_W(REG_W), .PC_W(PC_W)) u_merge (
    .hold_v(hold_v), .h_dst(h_dst), .h_sa(h_sa), .h_sb(h_sb), .h_pc(h_pc),
    .in_valid(in_valid), .in_cls(in_cls), .in_dst(in_dst), .in_sa(in_sa),
    .in_sb(in_sb), .in_pc(in_pc), .sel(sel), .hit(hit),
    .u_kind(u_kind), .u_dst(u_dst), .u_sa(u_sa), .u_sn(u_sn), .u_sm(u_sm),
    .u_pc(u_pc), .u_pc2(u_pc2)
  );

  assign uop_d = {u_kind, u_dst, u_sa, u_sn, u_sm, u_pc, u_pc2};

  pfx_fuse_outreg #(.W(UOP_W)) u_out (
    .clk(clk), .rst_n(rst_n), .emit(emit), .din(uop_d), .out_ready(out_ready),
    .out_valid(out_valid), .dout(uop_q), .can_load(adv)
  );

  assign {out_kind, out_dst, out_sa, out_sn, out_sm, out_pc, out_pc2} = uop_q;

  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8
  AST_FUSE_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && adv) |-> in_ready); // R2
  AST_PASS_PC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind != 2'd3) |-> (out_pc == out_pc2)); // R10
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_ready) && !$past(hold_v) && !$past(out_valid)) |-> !out_valid); // R1
endmodule

// File: tb/sim_pfx_fuse_stage.sv
`timescale 1ns/1ps
module sim_pfx_fuse_stage;
  localparam int RW = 5;
  localparam int PW = 32;
  localparam int HOLD = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_cls = '0;
  logic [RW-1:0] in_dst = '0, in_sa = '0, in_sb = '0;
  logic [PW-1:0] in_pc = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] out_kind;
  logic [RW-1:0] out_dst, out_sa, out_sn, out_sm;
  logic [PW-1:0] out_pc, out_pc2;

  always #2 clk = ~clk;

  pfx_fuse_stage #(.REG_W(RW), .PC_W(PW), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_sa(in_sa), .in_sb(in_sb), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dst(out_dst), .out_sa(out_sa), .out_sn(out_sn), .out_sm(out_sm),
    .out_pc(out_pc), .out_pc2(out_pc2)
  );

  int checks = 0;
  int fails = 0;
  int cur_req = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  logic [1:0]    e_kind [0:255];
  logic [RW-1:0] e_dst [0:255], e_sa [0:255], e_sn [0:255], e_sm [0:255];
  logic [PW-1:0] e_pc [0:255], e_pc2 [0:255];
  int            e_req [0:255];
  int exp_wr = 0;
  int exp_rd = 0;

  logic [1:0]    s_cls [0:63];
  logic [RW-1:0] s_dst [0:63], s_sa [0:63], s_sb [0:63];
  logic [PW-1:0] s_pc [0:63];
  int            s_gap [0:63];
  int pc_seed = 32'h1000;

  always @(negedge clk) out_ready <= bp_en ? 1'($urandom % 2) : 1'b1;

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired (R7): actual hung, expected completion");
    finish_up();
  end

  // Output monitor: each transfer is compared against the expected queue (R7)
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_rd >= exp_wr) begin
        fails++;
        $display("FAIL R7 unexpected output kind=%0d pc=%h, expected none", out_kind, out_pc);
      end else begin
        if (out_kind !== e_kind[exp_rd] || out_dst !== e_dst[exp_rd] ||
            out_sa !== e_sa[exp_rd] || out_sn !== e_sn[exp_rd] || out_sm !== e_sm[exp_rd] ||
            out_pc !== e_pc[exp_rd] || out_pc2 !== e_pc2[exp_rd]) begin
          fails++;
          $display("FAIL R%0d out #%0d actual k=%0d d=%0d a=%0d n=%0d m=%0d pc=%h pc2=%h expected k=%0d d=%0d a=%0d n=%0d m=%0d pc=%h pc2=%h",
                   e_req[exp_rd], exp_rd, out_kind, out_dst, out_sa, out_sn, out_sm, out_pc, out_pc2,
                   e_kind[exp_rd], e_dst[exp_rd], e_sa[exp_rd], e_sn[exp_rd], e_sm[exp_rd],
                   e_pc[exp_rd], e_pc2[exp_rd]);
        end
        exp_rd++;
      end
    end
  end

  task automatic push_pass(input int i);
    e_kind[exp_wr] = s_cls[i]; e_dst[exp_wr] = s_dst[i]; e_sa[exp_wr] = s_sa[i];
    e_sn[exp_wr] = s_sb[i]; e_sm[exp_wr] = '0; e_pc[exp_wr] = s_pc[i];
    e_pc2[exp_wr] = s_pc[i]; e_req[exp_wr] = cur_req; exp_wr++;
  endtask

  task automatic push_fused(input int p, input int f);
    e_kind[exp_wr] = 2'd3; e_dst[exp_wr] = s_dst[f]; e_sa[exp_wr] = s_sa[p];
    e_sn[exp_wr] = s_sa[f]; e_sm[exp_wr] = s_sb[f]; e_pc[exp_wr] = s_pc[p];
    e_pc2[exp_wr] = s_pc[f]; e_req[exp_wr] = cur_req; exp_wr++;
  endtask

  task automatic set_item(input int i, input logic [1:0] c, input int d, input int a,
                          input int b, input int gap);
    s_cls[i] = c; s_dst[i] = RW'(d); s_sa[i] = RW'(a); s_sb[i] = RW'(b);
    s_pc[i] = PW'(pc_seed); pc_seed += 4; s_gap[i] = gap;
  endtask

  task automatic drive_one(input int i);
    for (int g = 0; g < s_gap[i]; g++) begin
      @(negedge clk); in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_cls = s_cls[i]; in_dst = s_dst[i];
    in_sa = s_sa[i]; in_sb = s_sb[i]; in_pc = s_pc[i];
    forever begin
      #0.5;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  // Reference model: fuse when a prefix is followed by a same-destination
  // multiply-add within the allowed idle gap; everything else alone, in order.
  task automatic run_stream(input int n);
    int i = 0;
    int start_wr = exp_wr;
    while (i < n) begin
      if (s_cls[i] == 2'd1 && i + 1 < n && s_cls[i+1] == 2'd2 &&
          s_dst[i+1] == s_dst[i] && s_gap[i+1] <= HOLD) begin
        push_fused(i, i + 1);
        i += 2;
      end else begin
        push_pass(i);
        i += 1;
      end
    end
    for (int k = 0; k < n; k++) drive_one(k);
    @(negedge clk); in_valid = 1'b0;
    for (int w = 0; w < 300 && exp_rd < exp_wr; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    checks++;
    if (exp_rd != exp_wr) begin
      fails++;
      $display("FAIL R%0d stream drained actual %0d outputs, expected %0d",
               cur_req, exp_rd - start_wr, exp_wr - start_wr);
      exp_rd = exp_wr;
    end
  endtask

  task automatic t_reset();
    // R1: nothing leaves after reset
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 out_valid after reset actual %b expected 0", out_valid);
    end
  endtask

  task automatic t_fuse_basic();
    // R2, R3: matching prefix + multiply-add fuse, two program counters kept
    cur_req = 2;
    set_item(0, 2'd1, 7, 3, 0, 0);
    set_item(1, 2'd2, 7, 1, 2, 0);
    set_item(2, 2'd0, 9, 4, 5, 0);
    set_item(3, 2'd1, 12, 30, 0, 0);
    set_item(4, 2'd2, 12, 17, 18, 0);
    run_stream(5);
  endtask

  task automatic t_mismatch();
    // R4: different destinations are not fused
    cur_req = 4;
    set_item(0, 2'd1, 7, 3, 0, 0);
    set_item(1, 2'd2, 8, 1, 2, 0);
    set_item(2, 2'd2, 8, 5, 6, 0);
    run_stream(3);
  endtask

  task automatic t_pfx_other();
    // R5 and R10: prefix then a plain record, both unchanged
    cur_req = 5;
    set_item(0, 2'd1, 4, 2, 1, 0);
    set_item(1, 2'd0, 4, 6, 7, 0);
    set_item(2, 2'd0, 11, 13, 14, 0);
    run_stream(3);
  endtask

  task automatic t_pfx_pfx();
    // R9: back-to-back prefixes, second one fuses with its follower
    cur_req = 9;
    set_item(0, 2'd1, 5, 1, 0, 0);
    set_item(1, 2'd1, 5, 2, 0, 0);
    set_item(2, 2'd2, 5, 3, 4, 0);
    run_stream(3);
  endtask

  task automatic t_gap();
    // R6: one idle cycle still fuses, two idle cycles split the pair
    cur_req = 6;
    set_item(0, 2'd1, 6, 1, 0, 0);
    set_item(1, 2'd2, 6, 2, 3, 1);
    set_item(2, 2'd1, 6, 4, 0, 0);
    set_item(3, 2'd2, 6, 5, 7, 2);
    run_stream(4);
  endtask

  task automatic t_tail();
    // R6: a prefix at the end of the buffer leaves alone
    cur_req = 6;
    set_item(0, 2'd0, 2, 3, 4, 0);
    set_item(1, 2'd1, 10, 20, 0, 0);
    run_stream(2);
  endtask

  task automatic t_random();
    // R7, R8: random stream under random output back-pressure
    cur_req = 7;
    bp_en = 1'b1;
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 40; i++)
        set_item(i, 2'($urandom % 3), int'($urandom % 3), int'($urandom % 32),
                 int'($urandom % 32), 0);
      run_stream(40);
    end
    bp_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_fuse_basic();
    t_mismatch();
    t_pfx_other();
    t_pfx_pfx();
    t_gap();
    t_tail();
    t_random();
    finish_up();
  end
endmodule